// File: doc/BRIEF.md
# SS7 Transmit Fill-In Unit Generator

This block sits in front of an HDLC framer on an SS7 signalling link and chooses, frame by frame, which octets the framer sends. Signal units arrive as octet streams on a write port and are staged in a two-slot buffer. Each unit taken from that buffer is sent once, or sent again and again while a repeat mode input is high. When no unit is waiting and repeat is not in force, the block can fill the link with three-octet fill-in units that reuse the sequence octets of the last unit it sent.

A unit that arrives while another frame is on the wire waits for that frame to end. The frame in progress is never cut, whether it is a fill-in unit or a repeated unit. Flags, CRC and bit stuffing are added downstream. The output is a plain octet stream with start and end markers and a ready/valid handshake.

Top module: `ss7_fill_tx`

## Requirements
- R1: During and right after reset, out_valid, out_sof and out_eof are 0 and in_ready is 1.
- R2: With repeat and auto-fill off, a written unit is sent exactly once, octets in write order, with out_sof on its first octet and out_eof on its last.
- R3: While rep_mode is 1, the unit last taken from the buffer is sent again after each complete copy, for as long as no new unit is staged.
- R4: A newly staged unit starts only after the eof octet of the frame in progress. When out_ready is held high, its first octet is accepted exactly two cycles after that eof octet.
- R5: While auto_fill is 1 and nothing else is due, fill-in frames of three octets are sent: backward octet, forward octet, then 8'h00. Each starts two cycles after the previous eof octet when out_ready is held high.
- R6: The backward and forward octets of a fill-in frame are the first and second octets of the most recent unit taken from the buffer. After reset they are both 8'hFF.
- R7: When nothing is staged and both rep_mode and auto_fill are 0, no octet is offered once the frame in progress ends.
- R8: At a frame boundary a staged unit wins over a repeat, and a repeat wins over a fill-in frame.
- R9: While out_valid is 1 and out_ready is 0, out_data, out_sof and out_eof hold their values and out_valid stays 1.
- R10: Only one unit can be staged. in_ready drops in the cycle after the last octet of a unit is accepted, and it returns to 1 once that unit starts.
- R11: Octets beyond MAX_UNIT in one unit are dropped. The unit is sent with its first MAX_UNIT octets, and the last of those carries out_eof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rep_mode | input | 1 | 1: keep resending the current unit until a new one is staged |
| auto_fill | input | 1 | 1: send fill-in units when idle |
| in_valid | input | 1 | Write octet valid |
| in_ready | output | 1 | Write side can accept an octet |
| in_data | input | 8 | Unit octet |
| in_last | input | 1 | Marks the final octet of a unit |
| out_valid | output | 1 | Octet offered to the framer |
| out_ready | input | 1 | Framer takes the octet |
| out_data | output | 8 | Octet to the framer |
| out_sof | output | 1 | First octet of a frame |
| out_eof | output | 1 | Last octet of a frame |

## Verification
The bench stages a unit while fill-in frames are running and while a unit is being repeated, and checks that the switch lands exactly on a frame boundary. A design that switched early would cut a frame short, and one that held a stale slot would go on repeating the old unit. Fill octets are checked before any unit has been sent and after each new unit, which catches sequence octets captured from the wrong position or never refreshed. A stalled framer combined with a second staged unit exercises the one-slot limit on the write side, and an over-long unit exercises truncation; a design that got either wrong would lose the eof marker or overwrite the unit being sent.

// File: rtl/ss7fill_pkg.sv
package ss7fill_pkg;
  typedef enum logic [1:0] {
    ST_PICK = 2'd0,
    ST_UNIT = 2'd1,
    ST_FILL = 2'd2
  } tx_state_e;

  localparam logic [7:0] SEQ_RESET = 8'hFF;
  localparam logic [7:0] FILL_LI   = 8'h00;
endpackage

// File: rtl/ss7fill_unit_buf.sv
module ss7fill_unit_buf #(
  parameter int MAX_UNIT = 272,
  parameter int AW       = $clog2(MAX_UNIT),
  parameter int LW       = $clog2(MAX_UNIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          take,
  output logic          pend,
  output logic [LW-1:0] pend_len,
  output logic          pend_slot,
  input  logic [AW:0]   rd_addr,
  output logic [7:0]    rd_q
);
  localparam int DEPTH = 2 ** (AW + 1);
  localparam logic [LW-1:0] MAX_L = LW'(MAX_UNIT);

  logic [7:0]    mem [DEPTH];
  logic          wr_slot;
  logic [LW-1:0] wr_ptr;
  logic          accept;
  logic          room;

  assign accept    = in_valid && in_ready;
  assign room      = (wr_ptr < MAX_L);
  assign in_ready  = !pend;
  assign pend_slot = wr_slot;

  // storage: plain write port and registered read port
  always_ff @(posedge clk) begin
    if (accept && room) begin
      mem[{wr_slot, wr_ptr[AW-1:0]}] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end

  // slot bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot  <= 1'b0;
      wr_ptr   <= '0;
      pend     <= 1'b0;
      pend_len <= '0;
    end else begin
      if (accept) begin
        if (in_last) begin
          pend     <= 1'b1;
          pend_len <= room ? (wr_ptr + 1'b1) : wr_ptr;
          wr_ptr   <= '0;
        end else if (room) begin
          wr_ptr <= wr_ptr + 1'b1;
        end
      end
      if (take) begin
        pend    <= 1'b0;
        wr_slot <= ~wr_slot;
      end
    end
  end
endmodule

// File: rtl/ss7fill_seq_reg.sv
module ss7fill_seq_reg
  import ss7fill_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_bwd,
  input  logic       cap_fwd,
  input  logic [7:0] cap_data,
  output logic [7:0] bwd_q,
  output logic [7:0] fwd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bwd_q <= SEQ_RESET;
      fwd_q <= SEQ_RESET;
    end else begin
      if (cap_bwd) bwd_q <= cap_data;
      if (cap_fwd) fwd_q <= cap_data;
    end
  end
endmodule

// File: rtl/ss7fill_sched.sv
module ss7fill_sched
  import ss7fill_pkg::*;
#(
  parameter int MAX_UNIT = 272,
  parameter int AW       = $clog2(MAX_UNIT),
  parameter int LW       = $clog2(MAX_UNIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rep_mode,
  input  logic          auto_fill,
  input  logic          pend,
  input  logic [LW-1:0] pend_len,
  input  logic          pend_slot,
  output logic          take,
  output logic [AW:0]   rd_addr,
  input  logic [7:0]    rd_q,
  input  logic [7:0]    bwd_q,
  input  logic [7:0]    fwd_q,
  output logic          cap_bwd,
  output logic          cap_fwd,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_sof,
  output logic          out_eof
);
  localparam logic [LW-1:0] IDX_ONE = LW'(1);
  localparam logic [LW-1:0] IDX_TWO = LW'(2);

  tx_state_e     state, state_n;
  logic          cur_slot, slot_n;
  logic [LW-1:0] cur_len, len_n;
  logic          have_cur, have_n;
  logic [LW-1:0] idx, idx_n;
  logic          ov_n, sof_n, eof_n;
  logic [7:0]    od_n;
  logic          adv;

  assign adv = !out_valid || out_ready;

  always_comb begin
    state_n = state;
    slot_n  = cur_slot;
    len_n   = cur_len;
    have_n  = have_cur;
    idx_n   = idx;
    ov_n    = out_valid;
    od_n    = out_data;
    sof_n   = out_sof;
    eof_n   = out_eof;
    take    = 1'b0;
    cap_bwd = 1'b0;
    cap_fwd = 1'b0;
    case (state)
      ST_PICK: begin
        if (adv) begin
          ov_n  = 1'b0;
          sof_n = 1'b0;
          eof_n = 1'b0;
        end
        idx_n = '0;
        if (pend) begin
          take    = 1'b1;
          slot_n  = pend_slot;
          len_n   = pend_len;
          have_n  = 1'b1;
          state_n = ST_UNIT;
        end else if (rep_mode && have_cur) begin
          state_n = ST_UNIT;
        end else if (auto_fill) begin
          state_n = ST_FILL;
        end
      end
      ST_UNIT: begin
        if (adv) begin
          ov_n    = 1'b1;
          od_n    = rd_q;
          sof_n   = (idx == '0);
          eof_n   = (idx == cur_len - IDX_ONE);
          cap_bwd = (idx == '0);
          cap_fwd = (idx == IDX_ONE);
          idx_n   = idx + IDX_ONE;
          if (idx == cur_len - IDX_ONE) state_n = ST_PICK;
        end
      end
      ST_FILL: begin
        if (adv) begin
          ov_n  = 1'b1;
          od_n  = (idx == '0) ? bwd_q : ((idx == IDX_ONE) ? fwd_q : FILL_LI);
          sof_n = (idx == '0);
          eof_n = (idx == IDX_TWO);
          idx_n = idx + IDX_ONE;
          if (idx == IDX_TWO) state_n = ST_PICK;
        end
      end
      default: state_n = ST_PICK;
    endcase
    rd_addr = {slot_n, idx_n[AW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PICK;
      cur_slot  <= 1'b0;
      cur_len   <= '0;
      have_cur  <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      state     <= state_n;
      cur_slot  <= slot_n;
      cur_len   <= len_n;
      have_cur  <= have_n;
      idx       <= idx_n;
      out_valid <= ov_n;
      out_data  <= od_n;
      out_sof   <= sof_n;
      out_eof   <= eof_n;
    end
  end
endmodule

// File: rtl/ss7_fill_tx.sv
module ss7_fill_tx #(
  parameter int MAX_UNIT = 272
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rep_mode,
  input  logic       auto_fill,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  localparam int AW = $clog2(MAX_UNIT);
  localparam int LW = $clog2(MAX_UNIT + 1);

  logic          take;
  logic          pend;
  logic [LW-1:0] pend_len;
  logic          pend_slot;
  logic [AW:0]   rd_addr;
  logic [7:0]    rd_q;
  logic          cap_bwd, cap_fwd;
  logic [7:0]    bwd_q, fwd_q;

  ss7fill_unit_buf #(.MAX_UNIT(MAX_UNIT), .AW(AW), .LW(LW)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .take      (take),
    .pend      (pend),
    .pend_len  (pend_len),
    .pend_slot (pend_slot),
    .rd_addr   (rd_addr),
    .rd_q      (rd_q)
  );

  ss7fill_seq_reg u_seq (
    .clk      (clk),
    .rst      (rst),
    .cap_bwd  (cap_bwd),
    .cap_fwd  (cap_fwd),
    .cap_data (rd_q),
    .bwd_q    (bwd_q),
    .fwd_q    (fwd_q)
  );

  ss7fill_sched #(.MAX_UNIT(MAX_UNIT), .AW(AW), .LW(LW)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .rep_mode  (rep_mode),
    .auto_fill (auto_fill),
    .pend      (pend),
    .pend_len  (pend_len),
    .pend_slot (pend_slot),
    .take      (take),
    .rd_addr   (rd_addr),
    .rd_q      (rd_q),
    .bwd_q     (bwd_q),
    .fwd_q     (fwd_q),
    .cap_bwd   (cap_bwd),
    .cap_fwd   (cap_fwd),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );
endmodule

// File: rtl/ss7fill_chk.sv
module ss7fill_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof
);
  logic in_frame;

  always_ff @(posedge clk) begin
    if (rst) in_frame <= 1'b0;
    else if (out_valid && out_ready) in_frame <= !out_eof;
  end

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

  // R10
  one_staged_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_last |=> !in_ready);

  // R2
  marker_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_sof && !out_eof);

  // R2
  frame_open_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !in_frame |-> out_sof);

  // R4
  no_cut_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && in_frame |-> !out_sof);
endmodule

bind ss7_fill_tx ss7fill_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof)
);

// File: tb/ss7_fill_tx_tb.sv
module ss7_fill_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rep_mode = 1'b0;
  logic       auto_fill = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sof;
  logic       out_eof;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lc = 0;
  logic [7:0] log_d [4096];
  logic       log_s [4096];
  logic       log_e [4096];
  int         log_c [4096];

  always #2 clk = ~clk;

  ss7_fill_tx #(.MAX_UNIT(8)) u_dut (
    .clk(clk), .rst(rst), .rep_mode(rep_mode), .auto_fill(auto_fill),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst && out_valid && out_ready && lc < 4096) begin
      log_d[lc] = out_data;
      log_s[lc] = out_sof;
      log_e[lc] = out_eof;
      log_c[lc] = cyc;
      lc++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_unit(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_data  = 8'(base + k);
      in_last  = (k == n - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic chk_frame(input int at, input int n, input int base, input string req);
    for (int k = 0; k < n; k++) begin
      chk(log_d[at+k] == 8'(base + k), req, int'(log_d[at+k]), base + k);
      chk(log_s[at+k] == (k == 0), req, int'(log_s[at+k]), int'(k == 0));
      chk(log_e[at+k] == (k == n - 1), req, int'(log_e[at+k]), int'(k == n - 1));
    end
  endtask

  task automatic chk_fills(input int from, input int to, input int b, input int f, input string req);
    for (int j = from; j + 2 < to; j += 3) begin
      chk(log_d[j] == 8'(b) && log_d[j+1] == 8'(f) && log_d[j+2] == 8'h00,
          req, {8'h0, log_d[j], log_d[j+1], log_d[j+2]}, (b << 16) | (f << 8));
      chk(log_s[j] && log_e[j+2] && !log_e[j] && !log_s[j+2], req,
          int'({log_s[j], log_e[j+2]}), 3);
      if (j > from) chk(log_c[j] - log_c[j-1] == 2, "R5 spacing", log_c[j] - log_c[j-1], 2);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid && !out_sof && !out_eof, "R1 outputs", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready", int'(in_ready), 1);
    wait_cyc(10);
    chk(lc == 0, "R7 idle", lc, 0);
  endtask

  task automatic t_fill_reset;
    int s;
    s = lc;
    auto_fill = 1'b1;
    wait_cyc(14);
    auto_fill = 1'b0;
    wait_cyc(10);
    chk(lc > s && (lc - s) % 3 == 0, "R5 count", lc - s, 3);
    chk_fills(s, lc, 8'hFF, 8'hFF, "R6 reset octets");
  endtask

  task automatic t_single;
    int s;
    s = lc;
    push_unit(5, 8'h10);
    wait_cyc(20);
    chk(lc - s == 5, "R2/R7 count", lc - s, 5);
    chk_frame(s, 5, 8'h10, "R2 frame");
  endtask

  task automatic t_fill_after;
    int s;
    s = lc;
    auto_fill = 1'b1;
    wait_cyc(14);
    auto_fill = 1'b0;
    wait_cyc(10);
    chk(lc > s && (lc - s) % 3 == 0, "R5 count", lc - s, 3);
    chk_fills(s, lc, 8'h10, 8'h11, "R6 fill octets");
  endtask

  task automatic t_preempt;
    int s, j;
    s = lc;
    auto_fill = 1'b1;
    wait_cyc(6);
    push_unit(4, 8'h20);
    wait_cyc(20);
    auto_fill = 1'b0;
    wait_cyc(10);
    j = -1;
    for (int k = s; k < lc; k++) if (j < 0 && log_d[k] == 8'h20 && log_s[k]) j = k;
    chk(j > s, "R4 unit found after fill", j, s + 3);
    if (j > s) begin
      chk((j - s) % 3 == 0 && log_e[j-1], "R4 boundary", j - s, 3);
      chk(log_c[j] - log_c[j-1] == 2, "R4 spacing", log_c[j] - log_c[j-1], 2);
      chk_frame(j, 4, 8'h20, "R8 unit");
      chk(lc - (j + 4) >= 3, "R5 fills after", lc - (j + 4), 3);
      chk_fills(j + 4, lc, 8'h20, 8'h21, "R6 new octets");
    end
  endtask

  task automatic t_repeat;
    int s, j;
    s = lc;
    push_unit(3, 8'h30);
    rep_mode  = 1'b1;
    auto_fill = 1'b1;
    wait_cyc(25);
    push_unit(3, 8'h40);
    wait_cyc(20);
    rep_mode  = 1'b0;
    auto_fill = 1'b0;
    wait_cyc(20);
    j = -1;
    for (int k = s; k < lc; k++) if (j < 0 && log_d[k] == 8'h40) j = k;
    chk(j - s >= 6, "R3 copies before switch", j - s, 6);
    chk(j > s && (j - s) % 3 == 0, "R4 repeat boundary", j - s, 0);
    for (int k = s; k + 2 < j; k += 3) chk_frame(k, 3, 8'h30, "R3 old copy");
    chk(lc - j >= 6 && (lc - j) % 3 == 0, "R3/R8 new copies", lc - j, 6);
    for (int k = j; k + 2 < lc; k += 3) chk_frame(k, 3, 8'h40, "R8 repeat over fill");
  endtask

  task automatic t_stall;
    int s;
    s = lc;
    fork
      push_unit(6, 8'h50);
      begin
        bit prev_stall = 1'b0;
        logic [7:0] prev_d = '0;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          if (prev_stall)
            chk(out_valid && out_data == prev_d, "R9 hold", int'(out_data), int'(prev_d));
          prev_stall = out_valid && !out_ready;
          prev_d = out_data;
          @(posedge clk);
          #1;
          out_ready = (i % 3 == 0);
        end
      end
    join
    out_ready = 1'b1;
    wait_cyc(10);
    chk(lc - s == 6, "R9 count", lc - s, 6);
    chk_frame(s, 6, 8'h50, "R9 frame");
  endtask

  task automatic t_staged;
    int s;
    s = lc;
    out_ready = 1'b0;
    push_unit(2, 8'h60);
    wait_cyc(5);
    push_unit(10, 8'h70);
    @(negedge clk);
    chk(!in_ready, "R10 in_ready low", int'(in_ready), 0);
    wait_cyc(3);
    chk(!in_ready, "R10 still low", int'(in_ready), 0);
    out_ready = 1'b1;
    wait_cyc(30);
    chk(in_ready, "R10 released", int'(in_ready), 1);
    chk(lc - s == 10, "R11 count", lc - s, 10);
    chk_frame(s, 2, 8'h60, "R10 first unit");
    chk_frame(s + 2, 8, 8'h70, "R11 truncated");
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    t_reset();
    t_fill_reset();
    t_single();
    t_fill_after();
    t_preempt();
    t_repeat();
    t_stall();
    t_staged();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule